// File: doc/BRIEF.md
# Script I/O Instruction Executor

This block carries out the three I/O-class instructions of a small script engine that steers a parallel peripheral bus: wait-for-selection, set control bits and clear control bits. A decoder upstream presents an opcode, a four-bit mask, a 32-bit jump target and the current sequential script pointer with a one-cycle valid strobe. The executor either starts a pending wait, or updates its control latches in a single cycle.

A pending wait watches three status inputs: selected, reselected and a host abort request. The first cycle in which any of them is high resolves the wait. The block then reports the next fetch address and an outcome code. Selection continues at the captured script pointer. Reselection and host abort both branch to the captured jump target. The set and clear instructions update an ACK latch, an ATN latch, a target-role bit and the ALU carry flag. While the target role is active, the bus drive enables for ACK and ATN stay off, so only the internal latches change.

Top module: `sio_exec`

## Requirements
- R1: After a synchronous reset, ack_lat, atn_lat, tgt_mode, carry, busy, done and next_vld are all 0.
- R2: When a pending wait resolves by selection alone, next_addr equals the seq_ptr value captured when the wait was issued, and outcome is 2'b01.
- R3: When a pending wait resolves by reselection without an abort, next_addr equals the captured op_jump and outcome is 2'b10.
- R4: When host_abort is high while a wait is pending, the wait ends, next_addr equals the captured op_jump and outcome is 2'b11.
- R5: When several status inputs are high in the same cycle, abort wins over reselect, and reselect wins over select. Exactly one outcome is reported, with next_vld high for one cycle.
- R6: An accepted wait (op_code 2'b01) raises busy after the issuing edge. Status inputs are sampled only from the next edge on. busy falls on the same edge at which next_vld rises. Any op_valid presented while busy is ignored.
- R7: A wait never changes tgt_mode, including a wait resolved by reselection.
- R8: A set (op_code 2'b10) with mask bit 0 sets ack_lat, and with mask bit 1 sets atn_lat. A clear (op_code 2'b11) with the same bits clears them.
- R9: A set or clear with mask bit 2 sets or clears tgt_mode.
- R10: A set or clear with mask bit 3 sets or clears carry.
- R11: A state bit whose mask bit is 0 keeps its value. All mask bits that are 1 update on the same edge.
- R12: An accepted set or clear updates the state on its issuing edge and raises done for that one following cycle. done also rises together with next_vld when a wait resolves.
- R13: bus_ack_oe equals ack_lat and bus_atn_oe equals atn_lat while tgt_mode is 0. Both are 0 while tgt_mode is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction presented this cycle |
| op_code | input | 2 | 00 none, 01 wait, 10 set, 11 clear |
| op_mask | input | 4 | bit0 ACK, bit1 ATN, bit2 target, bit3 carry |
| op_jump | input | ADDR_W | Branch target for reselect/abort |
| seq_ptr | input | ADDR_W | Sequential script pointer |
| sel_in | input | 1 | Device was selected |
| resel_in | input | 1 | Device was reselected |
| host_abort | input | 1 | Host signal-process request |
| busy | output | 1 | Wait pending |
| done | output | 1 | Instruction completed pulse |
| next_vld | output | 1 | Wait resolved, next_addr valid |
| next_addr | output | ADDR_W | Next fetch address |
| outcome | output | 2 | 01 selected, 10 reselected, 11 aborted |
| ack_lat | output | 1 | ACK output latch |
| atn_lat | output | 1 | ATN output latch |
| tgt_mode | output | 1 | Target-role control bit |
| carry | output | 1 | ALU carry flag |
| bus_ack_oe | output | 1 | ACK bus drive enable |
| bus_atn_oe | output | 1 | ATN bus drive enable |

## Verification
A corrupted latch bit shows up on the cycle after the faulty set or clear, either in the four state outputs or in the drive enables. A wrong priority decode shows up in outcome and next_addr on the same cycle the wait resolves. A stuck or missing pending flag is visible at once on busy, and one cycle later as a missing next_vld. The sweeps cover every mask value for both polarities, and every non-empty combination of the three status inputs.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned MASK_W = 4;
  localparam int unsigned BIT_ACK = 0;
  localparam int unsigned BIT_ATN = 1;
  localparam int unsigned BIT_TGT = 2;
  localparam int unsigned BIT_CAR = 3;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_WAIT = 2'b01,
    OP_SET  = 2'b10,
    OP_CLR  = 2'b11
  } sio_op_e;

  typedef enum logic [1:0] {
    RES_NONE  = 2'b00,
    RES_SEL   = 2'b01,
    RES_RESEL = 2'b10,
    RES_ABORT = 2'b11
  } sio_res_e;
endpackage

// File: rtl/sio_wait_unit.sv
module sio_wait_unit #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] jump,
  input  logic [ADDR_W-1:0] ptr,
  input  logic              sel,
  input  logic              resel,
  input  logic              abort,
  output logic              pending,
  output logic              res_vld,
  output logic [ADDR_W-1:0] res_addr,
  output logic [1:0]        res_code
);
  import sio_pkg::*;

  logic [ADDR_W-1:0] jump_q, ptr_q;
  logic              any_ev;
  sio_res_e          ev_code;

  assign any_ev = sel | resel | abort;

  // fixed priority: abort > reselect > select
  always_comb begin
    if (abort)      ev_code = RES_ABORT;
    else if (resel) ev_code = RES_RESEL;
    else            ev_code = RES_SEL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      res_vld  <= 1'b0;
      res_addr <= '0;
      res_code <= RES_NONE;
      jump_q   <= '0;
      ptr_q    <= '0;
    end else begin
      res_vld <= 1'b0;
      if (!pending) begin
        if (start) begin
          pending <= 1'b1;
          jump_q  <= jump;
          ptr_q   <= ptr;
        end
      end else if (any_ev) begin
        pending  <= 1'b0;
        res_vld  <= 1'b1;
        res_code <= ev_code;
        res_addr <= (ev_code == RES_SEL) ? ptr_q : jump_q;
      end
    end
  end
endmodule

// File: rtl/sio_ctl_bits.sv
module sio_ctl_bits #(
  parameter int unsigned NBITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             set_not_clr,
  input  logic [NBITS-1:0] mask,
  output logic [NBITS-1:0] state
);
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                   state[i] <= 1'b0;
      else if (wr_en && mask[i]) state[i] <= set_not_clr;
    end
  end
endmodule

// File: rtl/sio_exec.sv
module sio_exec #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [3:0]        op_mask,
  input  logic [ADDR_W-1:0] op_jump,
  input  logic [ADDR_W-1:0] seq_ptr,
  input  logic              sel_in,
  input  logic              resel_in,
  input  logic              host_abort,
  output logic              busy,
  output logic              done,
  output logic              next_vld,
  output logic [ADDR_W-1:0] next_addr,
  output logic [1:0]        outcome,
  output logic              ack_lat,
  output logic              atn_lat,
  output logic              tgt_mode,
  output logic              carry,
  output logic              bus_ack_oe,
  output logic              bus_atn_oe
);
  import sio_pkg::*;

  logic              accept, wait_go, bits_go;
  logic              ctl_done_q;
  logic [MASK_W-1:0] bits;

  assign accept  = op_valid && !busy;
  assign wait_go = accept && (op_code == OP_WAIT);
  assign bits_go = accept && ((op_code == OP_SET) || (op_code == OP_CLR));

  sio_wait_unit #(.ADDR_W(ADDR_W)) wait_i (
    .clk      (clk),
    .rst      (rst),
    .start    (wait_go),
    .jump     (op_jump),
    .ptr      (seq_ptr),
    .sel      (sel_in),
    .resel    (resel_in),
    .abort    (host_abort),
    .pending  (busy),
    .res_vld  (next_vld),
    .res_addr (next_addr),
    .res_code (outcome)
  );

  sio_ctl_bits #(.NBITS(MASK_W)) bits_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (bits_go),
    .set_not_clr (op_code == OP_SET),
    .mask        (op_mask),
    .state       (bits)
  );

  always_ff @(posedge clk) begin
    if (rst) ctl_done_q <= 1'b0;
    else     ctl_done_q <= bits_go;
  end

  assign done       = ctl_done_q | next_vld;
  assign ack_lat    = bits[BIT_ACK];
  assign atn_lat    = bits[BIT_ATN];
  assign tgt_mode   = bits[BIT_TGT];
  assign carry      = bits[BIT_CAR];
  assign bus_ack_oe = bits[BIT_ACK] & ~bits[BIT_TGT];
  assign bus_atn_oe = bits[BIT_ATN] & ~bits[BIT_TGT];
endmodule

// File: rtl/sio_exec_chk.sv
module sio_exec_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [1:0]        op_code,
  input logic [3:0]        op_mask,
  input logic              sel_in,
  input logic              resel_in,
  input logic              host_abort,
  input logic              busy,
  input logic              done,
  input logic              next_vld,
  input logic [ADDR_W-1:0] next_addr,
  input logic [1:0]        outcome,
  input logic              ack_lat,
  input logic              atn_lat,
  input logic              tgt_mode,
  input logic              carry,
  input logic              bus_ack_oe,
  input logic              bus_atn_oe
);
  // R5
  vld_has_code_chk: assert property (@(posedge clk) disable iff (rst)
    next_vld |-> (outcome != 2'b00));
  // R4
  abort_code_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && host_abort) |=> (next_vld && outcome == 2'b11));
  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !(sel_in || resel_in || host_abort)) |=> (busy && !next_vld));
  // R6
  wait_end_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && (sel_in || resel_in || host_abort)) |=> (!busy && next_vld && done));
  // R7
  wait_tgt_stable_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(tgt_mode));
  // R8
  ack_set_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy && op_code == 2'b10 && op_mask[0]) |=> ack_lat);
  // R11
  carry_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy && op_code[1] && !op_mask[3]) |=> $stable(carry));
  // R12
  ctl_done_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy && op_code[1]) |=> done);
  // R13
  tgt_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_mode |-> (!bus_ack_oe && !bus_atn_oe));
endmodule

bind sio_exec sio_exec_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_mask(op_mask),
  .sel_in(sel_in), .resel_in(resel_in), .host_abort(host_abort), .busy(busy),
  .done(done), .next_vld(next_vld), .next_addr(next_addr), .outcome(outcome),
  .ack_lat(ack_lat), .atn_lat(atn_lat), .tgt_mode(tgt_mode), .carry(carry),
  .bus_ack_oe(bus_ack_oe), .bus_atn_oe(bus_atn_oe)
);

// File: tb/sio_exec_tb_top.sv
`timescale 1ns/1ps
module sio_exec_tb_top;
  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [1:0]    op_code = 2'b00;
  logic [3:0]    op_mask = 4'h0;
  logic [AW-1:0] op_jump = '0;
  logic [AW-1:0] seq_ptr = '0;
  logic          sel_in = 1'b0, resel_in = 1'b0, host_abort = 1'b0;
  logic          busy, done, next_vld;
  logic [AW-1:0] next_addr;
  logic [1:0]    outcome;
  logic          ack_lat, atn_lat, tgt_mode, carry, bus_ack_oe, bus_atn_oe;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  logic [3:0] mv = 4'h0;

  always #2 clk = ~clk;

  sio_exec #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_mask(op_mask),
    .op_jump(op_jump), .seq_ptr(seq_ptr), .sel_in(sel_in), .resel_in(resel_in),
    .host_abort(host_abort), .busy(busy), .done(done), .next_vld(next_vld),
    .next_addr(next_addr), .outcome(outcome), .ack_lat(ack_lat), .atn_lat(atn_lat),
    .tgt_mode(tgt_mode), .carry(carry), .bus_ack_oe(bus_ack_oe), .bus_atn_oe(bus_atn_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [1:0] exp_oe(input logic [3:0] v);
    return {v[1] & ~v[2], v[0] & ~v[2]};
  endfunction

  // issue set/clear, then check state on the next negedge
  task automatic ctl_op(input logic [1:0] code, input logic [3:0] m);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_mask = m;
    @(negedge clk);
    op_valid = 1'b0; op_code = 2'b00;
    if (code == 2'b10) mv = mv | m; else mv = mv & ~m;
    // R8 R9 R10 R11: all four state bits {carry,tgt,atn,ack}
    chk("R8_R9_R10_R11 state", {28'd0, carry, tgt_mode, atn_lat, ack_lat}, {28'd0, mv});
    // R13 drive enables
    chk("R13 bus oe", {30'd0, bus_atn_oe, bus_ack_oe}, {30'd0, exp_oe(mv)});
    // R12 done pulse
    chk("R12 done high", {31'd0, done}, 32'd1);
    @(negedge clk);
    chk("R12 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic wait_op(input logic [2:0] ev, input logic [AW-1:0] jmp,
                         input logic [AW-1:0] ptr, input int idle);
    logic [1:0]    ecode;
    logic [AW-1:0] eaddr;
    @(negedge clk);
    op_valid = 1'b1; op_code = 2'b01; op_jump = jmp; seq_ptr = ptr;
    @(negedge clk);
    op_valid = 1'b0; op_code = 2'b00; op_jump = ~jmp; seq_ptr = ~ptr;
    chk("R6 busy after issue", {31'd0, busy}, 32'd1);
    for (int k = 0; k < idle; k++) begin
      @(negedge clk);
      chk("R6 busy while idle", {30'd0, busy, next_vld}, 32'd2);
    end
    {host_abort, resel_in, sel_in} = ev;
    @(negedge clk);
    {host_abort, resel_in, sel_in} = 3'b000;
    if (ev[2])      begin ecode = 2'b11; eaddr = jmp; end
    else if (ev[1]) begin ecode = 2'b10; eaddr = jmp; end
    else            begin ecode = 2'b01; eaddr = ptr; end
    // R2 R3 R4 R5
    chk("R2_R3_R4_R5 outcome", {30'd0, outcome}, {30'd0, ecode});
    chk("R2_R3_R4 next_addr", next_addr, eaddr);
    chk("R6 resolve busy/vld/done", {29'd0, busy, next_vld, done}, 32'd3);
    chk("R7 tgt unchanged", {28'd0, carry, tgt_mode, atn_lat, ack_lat}, {28'd0, mv});
    @(negedge clk);
    chk("R5 vld one cycle", {31'd0, next_vld}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 reset outputs",
        {25'd0, ack_lat, atn_lat, tgt_mode, carry, busy, done, next_vld}, 32'd0);

    // R8 R9 R10 R11 R12 R13: every mask under both polarities, two passes
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 16; m++) begin
        ctl_op(2'b10, 4'(m));
        ctl_op(2'b11, 4'(15 - m));
      end

    // waits with tgt 0, then tgt 1 (R7: reselect must not clear it)
    for (int t = 0; t < 2; t++) begin
      ctl_op(t ? 2'b10 : 2'b11, 4'b0111);
      for (int e = 1; e < 8; e++)
        wait_op(3'(e), 32'hA500_0000 + 32'(e), 32'h0000_1000 + 32'(e * 4), e % 3);
    end

    // R6: events high in the issue cycle are not sampled on that edge
    @(negedge clk);
    op_valid = 1'b1; op_code = 2'b01; op_jump = 32'hCAFE_0000; seq_ptr = 32'h44;
    sel_in = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; op_code = 2'b00;
    chk("R6 no resolve in issue cycle", {30'd0, busy, next_vld}, 32'd2);
    // R6: op while busy ignored
    sel_in = 1'b0;
    op_valid = 1'b1; op_code = 2'b10; op_mask = 4'hF;
    @(negedge clk);
    op_valid = 1'b0; op_code = 2'b00;
    chk("R6 ignored op state", {28'd0, carry, tgt_mode, atn_lat, ack_lat}, {28'd0, mv});
    chk("R6 ignored op no done", {31'd0, done}, 32'd0);
    resel_in = 1'b1;
    @(negedge clk);
    resel_in = 1'b0;
    chk("R3 late reselect addr", next_addr, 32'hCAFE_0000);
    chk("R3 late reselect code", {30'd0, outcome}, 32'd2);

    // R1 reset mid-state
    ctl_op(2'b10, 4'b1011);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset clears", {28'd0, carry, tgt_mode, atn_lat, ack_lat}, 32'd0);
    finish_run();
  end
endmodule